// File: doc/BRIEF.md
# Interrupt controller command decoder

This block is the command front end of one eight-input, vectored interrupt controller. It takes byte-wide writes and reads on two port addresses (an even port and an odd port) and on a separate trigger-mode register. It runs the initialization word sequence and keeps the mask, vector base and mode bits. It decodes the operation commands into end-of-interrupt and priority-rotation actions, and it keeps the read-select, poll and special-mask state. A companion priority resolver owns the request and in-service registers. This block shows them on reads and sends the resolver single-cycle strobes.

The initialization sequencer has four named states. SEQ_NORMAL is the operating state. SEQ_VBASE waits for the vector-base word. SEQ_CASCADE waits for the cascade word. SEQ_MODE waits for the optional mode word. The transitions are:
- T_INIT: any state to SEQ_VBASE, on an even-port write with bit 4 set.
- T_BASE: SEQ_VBASE to SEQ_CASCADE, on an odd-port write.
- T_CASC4: SEQ_CASCADE to SEQ_MODE, on an odd-port write when the first word had bit 0 set.
- T_CASC3: SEQ_CASCADE to SEQ_NORMAL, on an odd-port write when that bit was clear.
- T_MODE: SEQ_MODE to SEQ_NORMAL, on an odd-port write.

Even-port commands are taken in every state.

The parameter IS_MASTER picks the fixed mask applied to the trigger-mode register.

Top module: `pic_cmd_decoder`

## Requirements
- R1: An even-port write with bit 4 set (trig_sel low) gives a one-cycle init_stb in the next cycle. It clears imr, vec_base, rot_aeoi, sfnm, aeoi, special_mask, the poll flag and the read select (back to request register), and moves the sequencer to the vector-base step.
- R2: In the vector-base step, an odd-port write loads vec_base with bits 7:3 of the byte and bits 2:0 forced to zero. The sequencer then waits for the cascade word.
- R3: After the cascade word, a mode word is taken only if bit 0 of the first word was 1. The mode word sets sfnm from bit 4 and aeoi from bit 1, and it leaves imr unchanged. The sequencer then returns to normal.
- R4: In the normal state, an odd-port write loads imr, and an odd-port read returns imr on rdata.
- R5: An even-port write with bit 4 = 0 and bit 3 = 1 is a read-control command. If bit 1 = 1, bit 0 selects what later even-port reads return: 1 gives isr_in and 0 gives irr_in. If bit 6 = 1, special_mask takes bit 5. Otherwise both are unchanged.
- R6: A read-control command with bit 2 = 1 arms poll. The next even-port read returns 0x80 OR poll_lvl when poll_valid is 1, or 0x07 when it is 0. That read disarms poll.
- R7: An even-port write with bits 4:3 = 00 decodes bits 7:5 as a command. Code 1 gives clr_stb with clr_lvl = isr_top. Code 5 also gives base_stb with base_val = (isr_top + 1) mod 8. Both give nothing when isr_nonempty is 0. All strobes come one cycle after the write.
- R8: Code 3 gives clr_stb with clr_lvl = bits 2:0. Code 7 gives that plus base_stb with base_val = (bits 2:0 + 1) mod 8. Code 6 gives base_stb alone, with the same value.
- R9: Codes 0 and 4 load rot_aeoi from bit 7. Code 2 produces no strobe and changes no output.
- R10: A trig_sel write stores the byte ANDed with 0xF8 (IS_MASTER = 1) or 0xDE (IS_MASTER = 0). A trig_sel read returns the stored value.
- R11: After reset, every register output is zero, no strobe is high, and an even-port read returns irr_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr_odd | input | 1 | 0 selects the even port, 1 the odd port |
| trig_sel | input | 1 | Access the trigger-mode register instead |
| wdata | input | 8 | Write byte |
| irr_in | input | 8 | Request register from the resolver |
| isr_in | input | 8 | In-service register from the resolver |
| isr_nonempty | input | 1 | Some in-service bit is set |
| isr_top | input | 3 | Highest-priority in-service level |
| poll_valid | input | 1 | Resolver has a pending request |
| poll_lvl | input | 3 | Level of that request |
| rdata | output | 8 | Read byte, combinational while rd_en is high, else 0 |
| init_stb | output | 1 | Initialization reset pulse, drop the interrupt output |
| clr_stb | output | 1 | Clear the in-service bit clr_lvl |
| clr_lvl | output | 3 | Level to clear |
| base_stb | output | 1 | Load the priority base |
| base_val | output | 3 | New priority base |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| sfnm | output | 1 | Special fully nested mode |
| aeoi | output | 1 | Automatic end of interrupt |
| special_mask | output | 1 | Special mask mode |
| trig_mode | output | 8 | Masked trigger-mode register |

## Verification
The bench builds two copies side by side. One uses IS_MASTER = 1 and the other IS_MASTER = 0, so one all-ones write to the trigger-mode register shows both masks at once. The master copy carries every other check. It covers both initialization lengths, all eight command codes (including the empty in-service cases and the wrap from level 7 to base 0), and the poll outcomes with and without a pending request.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
    localparam int DATA_W = 8;
    localparam int LVL_W  = 3;

    typedef enum logic [1:0] {
        SEQ_NORMAL  = 2'd0,
        SEQ_VBASE   = 2'd1,
        SEQ_CASCADE = 2'd2,
        SEQ_MODE    = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_ROT_CLR   = 3'd0,
        OP_EOI       = 3'd1,
        OP_NOP       = 3'd2,
        OP_SPEC_EOI  = 3'd3,
        OP_ROT_SET   = 3'd4,
        OP_ROT_EOI   = 3'd5,
        OP_SET_BASE  = 3'd6,
        OP_ROT_SPEC  = 3'd7
    } op_code_t;

    function automatic logic [LVL_W-1:0] next_lvl(input logic [LVL_W-1:0] l);
        return l + 1'b1;
    endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_wr,
    input  logic              odd_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] imr,
    output logic [DATA_W-1:0] vec_base,
    output logic              sfnm,
    output logic              aeoi,
    output logic              init_stb
);
    localparam int BASE_LSB = LVL_W;

    seq_state_t state_q, state_d;
    logic       need_mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (init_wr) begin
            state_d = SEQ_VBASE;
        end else if (odd_wr) begin
            unique case (state_q)
                SEQ_NORMAL:  state_d = SEQ_NORMAL;
                SEQ_VBASE:   state_d = SEQ_CASCADE;
                SEQ_CASCADE: state_d = need_mode_q ? SEQ_MODE : SEQ_NORMAL;
                SEQ_MODE:    state_d = SEQ_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr         <= '0;
            vec_base    <= '0;
            sfnm        <= 1'b0;
            aeoi        <= 1'b0;
            need_mode_q <= 1'b0;
            init_stb    <= 1'b0;
        end else begin
            init_stb <= init_wr;
            if (init_wr) begin
                imr         <= '0;
                vec_base    <= '0;
                sfnm        <= 1'b0;
                aeoi        <= 1'b0;
                need_mode_q <= wdata[0];
            end else if (odd_wr) begin
                unique case (state_q)
                    SEQ_NORMAL:  imr <= wdata;
                    SEQ_VBASE:   vec_base <= {wdata[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
                    SEQ_CASCADE: ;
                    SEQ_MODE: begin
                        sfnm <= wdata[4];
                        aeoi <= wdata[1];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_wr,
    input  logic              ocw2_wr,
    input  logic              ocw3_wr,
    input  logic              poll_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              isr_nonempty,
    input  logic [LVL_W-1:0]  isr_top,
    output logic              clr_stb,
    output logic [LVL_W-1:0]  clr_lvl,
    output logic              base_stb,
    output logic [LVL_W-1:0]  base_val,
    output logic              rot_aeoi,
    output logic              rsel_isr,
    output logic              poll,
    output logic              special_mask
);
    op_code_t         op;
    logic [LVL_W-1:0] named;
    logic             clr_d, base_d;
    logic [LVL_W-1:0] clr_lvl_d, base_d_val;

    assign op    = op_code_t'(wdata[7:5]);
    assign named = wdata[LVL_W-1:0];

    always_comb begin
        clr_d      = 1'b0;
        base_d     = 1'b0;
        clr_lvl_d  = '0;
        base_d_val = '0;
        if (ocw2_wr) begin
            unique case (op)
                OP_ROT_CLR, OP_ROT_SET, OP_NOP: ;
                OP_EOI: begin
                    clr_d     = isr_nonempty;
                    clr_lvl_d = isr_top;
                end
                OP_ROT_EOI: begin
                    clr_d      = isr_nonempty;
                    base_d     = isr_nonempty;
                    clr_lvl_d  = isr_top;
                    base_d_val = next_lvl(isr_top);
                end
                OP_SPEC_EOI: begin
                    clr_d     = 1'b1;
                    clr_lvl_d = named;
                end
                OP_SET_BASE: begin
                    base_d     = 1'b1;
                    base_d_val = next_lvl(named);
                end
                OP_ROT_SPEC: begin
                    clr_d      = 1'b1;
                    base_d     = 1'b1;
                    clr_lvl_d  = named;
                    base_d_val = next_lvl(named);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_stb      <= 1'b0;
            clr_lvl      <= '0;
            base_stb     <= 1'b0;
            base_val     <= '0;
            rot_aeoi     <= 1'b0;
            rsel_isr     <= 1'b0;
            poll         <= 1'b0;
            special_mask <= 1'b0;
        end else begin
            clr_stb  <= clr_d;
            clr_lvl  <= clr_lvl_d;
            base_stb <= base_d;
            base_val <= base_d_val;
            if (init_wr) begin
                rot_aeoi     <= 1'b0;
                rsel_isr     <= 1'b0;
                poll         <= 1'b0;
                special_mask <= 1'b0;
            end else if (ocw3_wr) begin
                poll <= poll | wdata[2];
                if (wdata[1]) rsel_isr     <= wdata[0];
                if (wdata[6]) special_mask <= wdata[5];
            end else begin
                if (poll_rd) poll <= 1'b0;
                if (ocw2_wr && (op == OP_ROT_CLR || op == OP_ROT_SET))
                    rot_aeoi <= wdata[7];
            end
        end
    end
endmodule

// File: rtl/pic_trig_reg.sv
module pic_trig_reg
    import pic_cmd_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] trig_mode
);
    logic [DATA_W-1:0] keep_mask;

    generate
        if (IS_MASTER) begin : g_master
            assign keep_mask = 8'hF8;
        end else begin : g_slave
            assign keep_mask = 8'hDE;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       trig_mode <= '0;
        else if (trig_wr) trig_mode <= wdata & keep_mask;
    end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import pic_cmd_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr_odd,
    input  logic              trig_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] irr_in,
    input  logic [DATA_W-1:0] isr_in,
    input  logic              isr_nonempty,
    input  logic [LVL_W-1:0]  isr_top,
    input  logic              poll_valid,
    input  logic [LVL_W-1:0]  poll_lvl,
    output logic [DATA_W-1:0] rdata,
    output logic              init_stb,
    output logic              clr_stb,
    output logic [LVL_W-1:0]  clr_lvl,
    output logic              base_stb,
    output logic [LVL_W-1:0]  base_val,
    output logic [DATA_W-1:0] imr,
    output logic [DATA_W-1:0] vec_base,
    output logic              rot_aeoi,
    output logic              sfnm,
    output logic              aeoi,
    output logic              special_mask,
    output logic [DATA_W-1:0] trig_mode
);
    localparam logic [DATA_W-1:0] POLL_FLAG = 8'h80;
    localparam logic [DATA_W-1:0] POLL_NONE = 8'h07;

    logic port_wr, even_wr, odd_wr, init_wr, ocw2_wr, ocw3_wr;
    logic even_rd, poll_rd, rsel_isr, poll;

    assign port_wr = wr_en && !trig_sel;
    assign even_wr = port_wr && !addr_odd;
    assign odd_wr  = port_wr && addr_odd;
    assign init_wr = even_wr && wdata[4];
    assign ocw3_wr = even_wr && !wdata[4] && wdata[3];
    assign ocw2_wr = even_wr && !wdata[4] && !wdata[3];
    assign even_rd = rd_en && !trig_sel && !addr_odd;
    assign poll_rd = even_rd && poll;

    pic_init_seq u_seq (
        .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .odd_wr(odd_wr),
        .wdata(wdata), .imr(imr), .vec_base(vec_base), .sfnm(sfnm),
        .aeoi(aeoi), .init_stb(init_stb)
    );

    pic_ocw_decode u_ocw (
        .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .ocw2_wr(ocw2_wr),
        .ocw3_wr(ocw3_wr), .poll_rd(poll_rd), .wdata(wdata),
        .isr_nonempty(isr_nonempty), .isr_top(isr_top),
        .clr_stb(clr_stb), .clr_lvl(clr_lvl), .base_stb(base_stb),
        .base_val(base_val), .rot_aeoi(rot_aeoi), .rsel_isr(rsel_isr),
        .poll(poll), .special_mask(special_mask)
    );

    pic_trig_reg #(.IS_MASTER(IS_MASTER)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_wr(wr_en && trig_sel),
        .wdata(wdata), .trig_mode(trig_mode)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (trig_sel)      rdata = trig_mode;
            else if (addr_odd) rdata = imr;
            else if (poll)     rdata = poll_valid ? (POLL_FLAG | DATA_W'(poll_lvl)) : POLL_NONE;
            else               rdata = rsel_isr ? isr_in : irr_in;
        end
    end
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk
    import pic_cmd_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              addr_odd,
    input logic              trig_sel,
    input logic [DATA_W-1:0] wdata,
    input logic              isr_nonempty,
    input logic [LVL_W-1:0]  isr_top,
    input logic              init_stb,
    input logic              clr_stb,
    input logic [LVL_W-1:0]  clr_lvl,
    input logic              base_stb,
    input logic [LVL_W-1:0]  base_val,
    input logic [DATA_W-1:0] vec_base,
    input logic [DATA_W-1:0] trig_mode
);
    localparam logic [DATA_W-1:0] FORBID = IS_MASTER ? 8'h07 : 8'h21;

    logic even_cmd;
    assign even_cmd = wr_en && !trig_sel && !addr_odd && !wdata[4] && !wdata[3];

    // R1
    init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trig_sel && !addr_odd && wdata[4]) |=> init_stb);

    // R2
    base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_base[2:0] == 3'b000);

    // R7
    eoi_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (even_cmd && wdata[7:5] == 3'd1 && isr_nonempty)
        |=> (clr_stb && !base_stb && clr_lvl == $past(isr_top)));

    // R8
    rot_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (even_cmd && wdata[7:5] == 3'd7)
        |=> (clr_stb && base_stb && base_val == 3'(clr_lvl + 3'd1)));

    // R9
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (even_cmd && wdata[7:5] == 3'd2) |=> (!clr_stb && !base_stb));

    // R10
    trig_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode & FORBID) == '0);
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.IS_MASTER(IS_MASTER)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_odd(addr_odd),
    .trig_sel(trig_sel), .wdata(wdata), .isr_nonempty(isr_nonempty),
    .isr_top(isr_top), .init_stb(init_stb), .clr_stb(clr_stb),
    .clr_lvl(clr_lvl), .base_stb(base_stb), .base_val(base_val),
    .vec_base(vec_base), .trig_mode(trig_mode)
);

// File: tb/pic_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module pic_cmd_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr_odd = 1'b0, trig_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] irr_in = 8'h5A, isr_in = 8'hC3;
    logic       isr_nonempty = 1'b0, poll_valid = 1'b0;
    logic [2:0] isr_top = '0, poll_lvl = '0;
    logic [7:0] rdata, imr, vec_base, trig_mode, rdata_s, imr_s, vb_s, trig_s;
    logic       init_stb, clr_stb, base_stb, rot_aeoi, sfnm, aeoi, special_mask;
    logic [2:0] clr_lvl, base_val, cl_s, bv_s;
    logic       is_s, cs_s, bs_s, ra_s, sf_s, ae_s, sm_s;
    int errors = 0, checks = 0;

    always #2 clk = ~clk;

    pic_cmd_decoder #(.IS_MASTER(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr_odd(addr_odd), .trig_sel(trig_sel), .wdata(wdata),
        .irr_in(irr_in), .isr_in(isr_in), .isr_nonempty(isr_nonempty),
        .isr_top(isr_top), .poll_valid(poll_valid), .poll_lvl(poll_lvl),
        .rdata(rdata), .init_stb(init_stb), .clr_stb(clr_stb),
        .clr_lvl(clr_lvl), .base_stb(base_stb), .base_val(base_val),
        .imr(imr), .vec_base(vec_base), .rot_aeoi(rot_aeoi), .sfnm(sfnm),
        .aeoi(aeoi), .special_mask(special_mask), .trig_mode(trig_mode)
    );

    pic_cmd_decoder #(.IS_MASTER(1'b0)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr_odd(addr_odd), .trig_sel(trig_sel), .wdata(wdata),
        .irr_in(irr_in), .isr_in(isr_in), .isr_nonempty(isr_nonempty),
        .isr_top(isr_top), .poll_valid(poll_valid), .poll_lvl(poll_lvl),
        .rdata(rdata_s), .init_stb(is_s), .clr_stb(cs_s),
        .clr_lvl(cl_s), .base_stb(bs_s), .base_val(bv_s),
        .imr(imr_s), .vec_base(vb_s), .rot_aeoi(ra_s), .sfnm(sf_s),
        .aeoi(ae_s), .special_mask(sm_s), .trig_mode(trig_s)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge; on return the registered strobes of that write are visible
    task automatic wr(input logic odd, input logic tsel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr_odd = odd; trig_sel = tsel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; trig_sel = 1'b0;
        #0.5;
    endtask

    task automatic rd(input logic odd, input logic tsel, output logic [7:0] m, output logic [7:0] s);
        @(negedge clk);
        rd_en = 1'b1; addr_odd = odd; trig_sel = tsel;
        #1;
        m = rdata; s = rdata_s;
        @(negedge clk);
        rd_en = 1'b0; trig_sel = 1'b0;
    endtask

    // {cmd byte, isr_nonempty, isr_top, exp clr, exp clr_lvl, exp base, exp base_val}
    localparam int NVEC = 9;
    localparam logic [19:0] VECS [NVEC] = '{
        {8'h20, 1'b1, 3'd5, 1'b1, 3'd5, 1'b0, 3'd0},  // R7 code 1
        {8'h20, 1'b0, 3'd5, 1'b0, 3'd0, 1'b0, 3'd0},  // R7 code 1, nothing in service
        {8'hA0, 1'b1, 3'd7, 1'b1, 3'd7, 1'b1, 3'd0},  // R7 code 5, wrap
        {8'hA0, 1'b1, 3'd2, 1'b1, 3'd2, 1'b1, 3'd3},  // R7 code 5
        {8'hA0, 1'b0, 3'd2, 1'b0, 3'd0, 1'b0, 3'd0},  // R7 code 5, nothing in service
        {8'h63, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 3'd0},  // R8 code 3
        {8'hC4, 1'b1, 3'd1, 1'b0, 3'd0, 1'b1, 3'd5},  // R8 code 6
        {8'hE7, 1'b0, 3'd0, 1'b1, 3'd7, 1'b1, 3'd0},  // R8 code 7, wrap
        {8'h47, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0}   // R9 code 2
    };

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] m, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 imr", imr, 8'h00);
        chk("R11 vec_base", vec_base, 8'h00);
        chk("R11 strobes", {5'b0, init_stb, clr_stb, base_stb}, 8'h00);
        chk("R11 modes", {4'b0, rot_aeoi, sfnm, aeoi, special_mask}, 8'h00);
        chk("R11 trig", trig_mode, 8'h00);
        rd(1'b0, 1'b0, m, s);
        chk("R11 even read irr", m, 8'h5A);

        // R1 four-word init
        wr(1'b0, 1'b0, 8'h11);
        chk("R1 init_stb", {7'b0, init_stb}, 8'h01);
        @(negedge clk);
        chk("R1 init_stb one cycle", {7'b0, init_stb}, 8'h00);
        wr(1'b1, 1'b0, 8'h6F);
        chk("R2 vec_base", vec_base, 8'h68);
        wr(1'b1, 1'b0, 8'h04);
        chk("R3 cascade leaves imr", imr, 8'h00);
        wr(1'b1, 1'b0, 8'h12);
        chk("R3 mode word", {6'b0, sfnm, aeoi}, 8'h03);
        chk("R3 mode word leaves imr", imr, 8'h00);
        wr(1'b1, 1'b0, 8'hA5);
        chk("R4 imr write", imr, 8'hA5);
        rd(1'b1, 1'b0, m, s);
        chk("R4 odd read", m, 8'hA5);

        // R5 read select and special mask
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, m, s);
        chk("R5 select isr", m, 8'hC3);
        wr(1'b0, 1'b0, 8'h68);
        chk("R5 special mask set", {7'b0, special_mask}, 8'h01);
        rd(1'b0, 1'b0, m, s);
        chk("R5 select kept when bit1 clear", m, 8'hC3);
        wr(1'b0, 1'b0, 8'h28);
        chk("R5 special mask kept when bit6 clear", {7'b0, special_mask}, 8'h01);
        wr(1'b0, 1'b0, 8'h80);
        chk("R9 code 4 sets rot", {7'b0, rot_aeoi}, 8'h01);
        wr(1'b0, 1'b0, 8'h47);
        chk("R9 code 2 keeps rot", {7'b0, rot_aeoi}, 8'h01);

        // R1 three-word init clears everything set above
        wr(1'b0, 1'b0, 8'h10);
        chk("R1 clears imr", imr, 8'h00);
        chk("R1 clears modes", {4'b0, rot_aeoi, sfnm, aeoi, special_mask}, 8'h00);
        rd(1'b0, 1'b0, m, s);
        chk("R1 read select back to irr", m, 8'h5A);
        wr(1'b1, 1'b0, 8'h27);
        chk("R2 vec_base low bits forced", vec_base, 8'h20);
        wr(1'b1, 1'b0, 8'h00);
        wr(1'b1, 1'b0, 8'h3C);
        chk("R3 no mode word, imr loads", imr, 8'h3C);
        chk("R3 no mode word, modes kept", {6'b0, sfnm, aeoi}, 8'h00);
        wr(1'b0, 1'b0, 8'h00);
        chk("R9 code 0 clears rot", {7'b0, rot_aeoi}, 8'h00);

        // R6 poll
        poll_valid = 1'b1; poll_lvl = 3'd6;
        wr(1'b0, 1'b0, 8'h0C);
        rd(1'b0, 1'b0, m, s);
        chk("R6 poll pending", m, 8'h86);
        rd(1'b0, 1'b0, m, s);
        chk("R6 poll disarmed", m, 8'h5A);
        poll_valid = 1'b0;
        wr(1'b0, 1'b0, 8'h0C);
        rd(1'b0, 1'b0, m, s);
        chk("R6 poll none", m, 8'h07);

        // R10 trigger-mode mask
        wr(1'b0, 1'b1, 8'hFF);
        chk("R10 master mask", trig_mode, 8'hF8);
        chk("R10 slave mask", trig_s, 8'hDE);
        rd(1'b0, 1'b1, m, s);
        chk("R10 master read", m, 8'hF8);
        chk("R10 slave read", s, 8'hDE);
        chk("R10 imr untouched", imr, 8'h3C);

        // R7 R8 R9 command vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [19:0] v;
            v = VECS[i];
            isr_nonempty = v[11]; isr_top = v[10:8];
            wr(1'b0, 1'b0, v[19:12]);
            chk($sformatf("R7/R8/R9 clr vec %0d", i), {4'b0, clr_stb, clr_lvl & {3{clr_stb}}}, {4'b0, v[7:4]});
            chk($sformatf("R7/R8/R9 base vec %0d", i), {4'b0, base_stb, base_val & {3{base_stb}}}, {4'b0, v[3:0]});
        end
        chk("R9 code 2 leaves imr", imr, 8'h3C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule